// File: doc/BRIEF.md
# Soft Symbol Capture and Metric Formatter

This block is the input stage of a rate 1/2 or 1/3 convolutional decoder. A symbol source places three 3-bit soft-decision symbols on its outputs and pulls an active-low ready strobe. The block brings the strobe into the system clock domain and detects its falling edge. On that edge it captures the three symbols and returns a single-cycle acknowledge. It turns each symbol into an unsigned "likelihood of a one" metric and puts the set into the order that the node-sync select calls for.

Soft symbols arrive in one of two formats. The first is signed magnitude. The second is a two's-complement variant in which the magnitude bits of negative values are inverted. A format select input chooses between them. Hard-decision sources drive only the top bit of each symbol, tie the two lower bits high and select signed magnitude. The decoder core receives one registered metric set, with a valid pulse, for each strobe. The set holds until the next strobe. At rate 1/2 the third symbol takes no part.

Top module: `soft_sym_front`

## Requirements
- R1: Each falling edge of `drdy_n` gives exactly one one-cycle pulse on `ack`, with `metric_valid` high in the same cycle, on the third rising clock edge after the edge. Holding `drdy_n` low gives no further pulse. Symbols and control inputs are sampled on that third rising edge.
- R2: With `fmt_sm`=1 (signed magnitude), input codes 011,010,001,000 map to metrics 0,1,2,3 and codes 100,101,110,111 map to metrics 4,5,6,7.
- R3: With `fmt_sm`=0 (inverted two's complement), codes 011,010,001,000 map to 0,1,2,3 and codes 111,110,101,100 map to 4,5,6,7.
- R4: Hard-decision input (bit 2 carries the data, bits 1:0 = 11, `fmt_sm`=1) yields metric 0 for a zero and metric 7 for a one.
- R5: At rate 1/3 (`rate_half`=0), `sync_sel` = 00 or 11 outputs (G1,G2,G3) on (a,b,c), 01 outputs (G2,G3,G1) and 10 outputs (G3,G1,G2).
- R6: At rate 1/2 (`rate_half`=1), `sync_sel`=01 outputs (G2,G1) on (a,b) and every other code outputs (G1,G2). `metric_c` is 0, and `sym_g3` has no effect on any output.
- R7: After reset `ack`, `metric_valid` and all metrics are 0. Between strobes the metrics hold their last value whatever the symbol and control inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| drdy_n | input | 1 | Active-low symbol-ready strobe, asynchronous to clk |
| sym_g1 | input | 3 | First soft symbol |
| sym_g2 | input | 3 | Second soft symbol |
| sym_g3 | input | 3 | Third soft symbol |
| fmt_sm | input | 1 | 1: signed magnitude, 0: inverted two's complement |
| rate_half | input | 1 | 1: rate 1/2 (two symbols), 0: rate 1/3 |
| sync_sel | input | 2 | Node-sync reorder select |
| ack | output | 1 | One-cycle acknowledge per accepted symbol set |
| metric_valid | output | 1 | New metric set on the outputs this cycle |
| metric_a | output | 3 | First ordered metric |
| metric_b | output | 3 | Second ordered metric |
| metric_c | output | 3 | Third ordered metric (0 at rate 1/2) |

## Verification
A faulty edge detector shows up on `ack` within three cycles of a strobe. The fault appears as a missing pulse, a doubled pulse or a pulse at the wrong distance from the edge. A wrong code table or reorder path shows on the metric outputs in the same cycle as `metric_valid`. Sweeping every code in both formats and every select value at both rates exposes it at once. A capture enable that leaks shows up as metrics that change between strobes, which the hold checks after input disturbance catch.

// File: rtl/soft_sym_pkg.sv
package soft_sym_pkg;
  localparam int unsigned SYM_W_DEF   = 3;
  localparam int unsigned NUM_SYM     = 3;
  localparam int unsigned SYNC_DEF    = 2;

  typedef enum logic [1:0] {
    ORD_PASS  = 2'b00,
    ORD_ROT1  = 2'b01,
    ORD_ROT2  = 2'b10,
    ORD_PASS2 = 2'b11
  } ord_sel_e;
endpackage

// File: rtl/strobe_detect.sv
module strobe_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_n,
  output logic fall
);
  logic [SYNC_STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], drdy_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  // previous synchronised level high, current low
  assign fall = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/sym_metric.sv
module sym_metric #(
  parameter int unsigned SYM_W = 3
) (
  input  logic [SYM_W-1:0] sym,
  input  logic             fmt_sm,
  output logic [SYM_W-1:0] metric
);
  localparam int unsigned MAG_W = SYM_W - 1;
  localparam logic [SYM_W-1:0] MID = SYM_W'(1) << MAG_W;
  localparam logic [SYM_W-1:0] TOP = '1;

  logic [SYM_W-1:0] mag;

  always_comb begin
    mag = {1'b0, sym[MAG_W-1:0]};
    if (!sym[SYM_W-1])  metric = (MID - SYM_W'(1)) - mag;
    else if (fmt_sm)    metric = MID + mag;
    else                metric = TOP - mag;
  end
endmodule

// File: rtl/sym_order.sv
module sym_order
  import soft_sym_pkg::*;
#(
  parameter int unsigned SYM_W = 3
) (
  input  logic [SYM_W-1:0] in_a,
  input  logic [SYM_W-1:0] in_b,
  input  logic [SYM_W-1:0] in_c,
  input  logic             rate_half,
  input  logic [1:0]       sel,
  output logic [SYM_W-1:0] out_a,
  output logic [SYM_W-1:0] out_b,
  output logic [SYM_W-1:0] out_c
);
  ord_sel_e s;

  always_comb begin
    s = ord_sel_e'(sel);
    out_a = in_a;
    out_b = in_b;
    out_c = in_c;
    if (rate_half) begin
      out_c = '0;
      if (s == ORD_ROT1) begin
        out_a = in_b;
        out_b = in_a;
      end
    end else begin
      case (s)
        ORD_ROT1: begin out_a = in_b; out_b = in_c; out_c = in_a; end
        ORD_ROT2: begin out_a = in_c; out_b = in_a; out_c = in_b; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/soft_sym_front.sv
module soft_sym_front
  import soft_sym_pkg::*;
#(
  parameter int unsigned SYM_W       = SYM_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drdy_n,
  input  logic [SYM_W-1:0] sym_g1,
  input  logic [SYM_W-1:0] sym_g2,
  input  logic [SYM_W-1:0] sym_g3,
  input  logic             fmt_sm,
  input  logic             rate_half,
  input  logic [1:0]       sync_sel,
  output logic             ack,
  output logic             metric_valid,
  output logic [SYM_W-1:0] metric_a,
  output logic [SYM_W-1:0] metric_b,
  output logic [SYM_W-1:0] metric_c
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic cap;

  strobe_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk    (clk),
    .rst_n  (rst_s),
    .drdy_n (drdy_n),
    .fall   (cap)
  );

  logic [SYM_W-1:0] raw    [NUM_SYM];
  logic [SYM_W-1:0] conv_m [NUM_SYM];

  assign raw[0] = sym_g1;
  assign raw[1] = sym_g2;
  assign raw[2] = sym_g3;

  for (genvar i = 0; i < NUM_SYM; i++) begin : g_conv
    sym_metric #(.SYM_W(SYM_W)) u_conv (
      .sym    (raw[i]),
      .fmt_sm (fmt_sm),
      .metric (conv_m[i])
    );
  end

  logic [SYM_W-1:0] ord_a, ord_b, ord_c;

  sym_order #(.SYM_W(SYM_W)) u_ord (
    .in_a      (conv_m[0]),
    .in_b      (conv_m[1]),
    .in_c      (conv_m[2]),
    .rate_half (rate_half),
    .sel       (sync_sel),
    .out_a     (ord_a),
    .out_b     (ord_b),
    .out_c     (ord_c)
  );

  logic [SYM_W-1:0] ma_q, mb_q, mc_q, ma_d, mb_d, mc_d;
  logic             ack_q, vld_q;

  always_comb begin
    ma_d = ma_q;
    mb_d = mb_q;
    mc_d = mc_q;
    if (cap) begin
      ma_d = ord_a;
      mb_d = ord_b;
      mc_d = ord_c;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ma_q  <= '0;
      mb_q  <= '0;
      mc_q  <= '0;
      ack_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      ma_q  <= ma_d;
      mb_q  <= mb_d;
      mc_q  <= mc_d;
      ack_q <= cap;
      vld_q <= cap;
    end
  end

  assign ack          = ack_q;
  assign metric_valid = vld_q;
  assign metric_a     = ma_q;
  assign metric_b     = mb_q;
  assign metric_c     = mc_q;

  p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_s)
    ack |=> !ack);

  // the metric's top bit follows the symbol's sign in both formats (R3 too)
  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_s)
    conv_m[0][SYM_W-1] == sym_g1[SYM_W-1]);

  p_half_c_zero_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (metric_valid && $past(rate_half)) |-> (metric_c == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !cap |=> $stable({metric_a, metric_b, metric_c}));
endmodule

// File: tb/soft_sym_front_bench.sv
module soft_sym_front_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       drdy_n;
  logic [2:0] g1, g2, g3;
  logic       fmt_sm, rate_half;
  logic [1:0] sync_sel;
  logic       ack, metric_valid;
  logic [2:0] ma, mb, mc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [2:0] ea, eb, ec;

  always #2 clk = ~clk;

  soft_sym_front u_soft_sym_front (
    .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n),
    .sym_g1(g1), .sym_g2(g2), .sym_g3(g3),
    .fmt_sm(fmt_sm), .rate_half(rate_half), .sync_sel(sync_sel),
    .ack(ack), .metric_valid(metric_valid),
    .metric_a(ma), .metric_b(mb), .metric_c(mc)
  );

  function automatic logic [2:0] exp_metric(logic [2:0] s, logic sm);
    if (!s[2])  return 3'd3 - {1'b0, s[1:0]};
    else if (sm) return 3'd4 + {1'b0, s[1:0]};
    else        return 3'd7 - {1'b0, s[1:0]};
  endfunction

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic strobe(logic [2:0] a, logic [2:0] b, logic [2:0] c,
                        logic sm, logic rh, logic [1:0] sel, string req);
    logic [2:0] x, y, z;
    x = exp_metric(a, sm); y = exp_metric(b, sm); z = exp_metric(c, sm);
    if (rh) begin
      if (sel == 2'b01) begin ea = y; eb = x; end
      else begin ea = x; eb = y; end
      ec = 3'd0;
    end else begin
      case (sel)
        2'b01:   begin ea = y; eb = z; ec = x; end
        2'b10:   begin ea = z; eb = x; ec = y; end
        default: begin ea = x; eb = y; ec = z; end
      endcase
    end
    @(negedge clk);
    g1 = a; g2 = b; g3 = c; fmt_sm = sm; rate_half = rh; sync_sel = sel;
    drdy_n = 1'b0;
    @(negedge clk);
    check("R1 early ack", int'(ack), 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 ack", int'(ack), 1);
    check("R1 valid", int'(metric_valid), 1);
    check({req, " a"}, int'(ma), int'(ea));
    check({req, " b"}, int'(mb), int'(eb));
    check({req, " c"}, int'(mc), int'(ec));
    @(negedge clk);
    check("R1 single ack", int'(ack), 0);
    repeat (2) @(negedge clk);
    check("R1 no ack while low", int'(ack), 0);
    drdy_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic hold_check();
    g1 = 3'($urandom); g2 = 3'($urandom); g3 = 3'($urandom);
    fmt_sm = 1'($urandom); rate_half = 1'($urandom); sync_sel = 2'($urandom);
    repeat (4) @(negedge clk);
    check("R7 hold a", int'(ma), int'(ea));
    check("R7 hold b", int'(mb), int'(eb));
    check("R7 hold c", int'(mc), int'(ec));
    check("R7 no valid", int'(metric_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd2024);
    rst_n = 1'b0; drdy_n = 1'b1;
    g1 = 3'd0; g2 = 3'd0; g3 = 3'd0;
    fmt_sm = 1'b1; rate_half = 1'b0; sync_sel = 2'b00;
    repeat (3) @(negedge clk);
    check("R7 reset ack", int'(ack), 0);
    check("R7 reset valid", int'(metric_valid), 0);
    check("R7 reset metric", int'({ma, mb, mc}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // every code, both formats, passed straight through
    for (int k = 0; k < 8; k++) strobe(3'(k), 3'(k+1), 3'(k+2), 1'b1, 1'b0, 2'b00, "R2 sm");
    for (int k = 0; k < 8; k++) strobe(3'(k), 3'(k+3), 3'(k+5), 1'b0, 1'b0, 2'b00, "R3 tc");
    // hard decision
    strobe(3'b011, 3'b111, 3'b011, 1'b1, 1'b0, 2'b00, "R4 hard");
    check("R4 zero->0", int'(ma), 0);
    check("R4 one->7", int'(mb), 7);
    // orderings at rate 1/3
    for (int s = 0; s < 4; s++) strobe(3'b011, 3'b100, 3'b111, 1'b1, 1'b0, 2'(s), "R5 order");
    // rate 1/2: g3 must not matter
    for (int s = 0; s < 4; s++) begin
      strobe(3'b001, 3'b110, 3'b000, 1'b0, 1'b1, 2'(s), "R6 half");
      strobe(3'b001, 3'b110, 3'b111, 1'b0, 1'b1, 2'(s), "R6 g3 ignored");
    end
    hold_check();

    for (int n = 0; n < 150; n++) begin
      strobe(3'($urandom), 3'($urandom), 3'($urandom), 1'($urandom),
             1'($urandom), 2'($urandom), "R5/R6 random");
      if (n % 10 == 0) hold_check();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule